// File: doc/BRIEF.md
# Host Word to Long-Word Bus Converter

This block sits between a host data bus and a 32-bit internal path that reaches registers and memory. The host bus can run as a 16-bit bus or as a 32-bit bus, and a mode input selects which. In 16-bit mode a long word reaches the internal side in two host cycles: the low half is captured first, then the high half. After the high half is captured, the block raises a one-cycle commit pulse so that the surrounding logic can write the assembled long word. In 32-bit mode a single host cycle captures the whole word.

For reads, the block captures one long word into a read register. The source is either register space or memory space. In 16-bit mode a half-select input returns the word to the host one half at a time, low half first and high half second. In 32-bit mode the full word is driven and the half-select has no effect. An external controller drives every enable and select. The block does no access sequencing of its own.

Top module: `wlc_bus_converter`

## Requirements
- R1: While rst_ni is low, wdata_o, host_rdata_o and wr_commit_o are all zero.
- R2: In 16-bit mode (mode32_i=0), wr_lo_en_i alone loads host_wdata_i[15:0] into wdata_o[15:0] at the next clock edge. wdata_o[31:16] keeps its value.
- R3: In 16-bit mode, wr_hi_en_i loads host_wdata_i[15:0] into wdata_o[31:16] at the next clock edge. wdata_o[15:0] changes only if wr_lo_en_i is also high.
- R4: In 32-bit mode (mode32_i=1), if either write enable is high, all 32 bits of host_wdata_i load into wdata_o at the next clock edge.
- R5: wr_commit_o is high for exactly the one cycle after an edge at which the high half was loaded. That happens on wr_hi_en_i in 16-bit mode, or on either enable in 32-bit mode. A low-half-only load in 16-bit mode gives no pulse.
- R6: When rd_cap_en_i is high, the read register takes reg_rdata_i if rd_src_mem_i=0 and mem_rdata_i if rd_src_mem_i=1. When rd_cap_en_i is low, it keeps its value.
- R7: In 16-bit mode, host_rdata_o[15:0] carries the low half of the read register when rd_hi_sel_i=0 and the high half when rd_hi_sel_i=1. host_rdata_o[31:16] is zero.
- R8: In 32-bit mode, host_rdata_o carries the whole read register, whatever the value of rd_hi_sel_i.
- R9: With both write enables low, wdata_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode32_i | input | 1 | 1 selects the 32-bit host bus, 0 selects the 16-bit host bus |
| host_wdata_i | input | 32 | Host write data; only bits 15:0 are used in 16-bit mode |
| wr_lo_en_i | input | 1 | Low write half capture enable |
| wr_hi_en_i | input | 1 | High write half capture enable |
| rd_cap_en_i | input | 1 | Read capture enable |
| rd_hi_sel_i | input | 1 | Selects the high read half in 16-bit mode |
| rd_src_mem_i | input | 1 | Read source: 1 selects memory space, 0 selects register space |
| reg_rdata_i | input | 32 | Register-space read data |
| mem_rdata_i | input | 32 | Memory-space read data |
| wdata_o | output | 32 | Assembled long word for the internal path |
| wr_commit_o | output | 1 | One-cycle pulse after the high half is captured |
| host_rdata_o | output | 32 | Data returned to the host |

## Verification
The hardest cases to reach are the ones where the mode changes between the two halves of a 16-bit transfer. Others are cycles that load a half and switch the read half-select in the same cycle. In those cases stale halves and a missing or extra commit pulse show up. A directed prologue walks through clean 16-bit and 32-bit write and read sequences. After it, a long run of random cycles toggles the mode, every enable and both selects independently. A behavioural model checks each cycle.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
  parameter int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 2 * HALF_W;
  typedef enum logic {SRC_REG = 1'b0, SRC_MEM = 1'b1} rd_src_e;
endpackage

// File: rtl/wlc_write_capture.sv
module wlc_write_capture #(
  parameter int unsigned HALF_W = wlc_pkg::HALF_W,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode32_i,
  input  logic [WORD_W-1:0] bus_i,
  input  logic              lo_en_i,
  input  logic              hi_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  logic [HALF_W-1:0] lo_q, hi_q, hi_din;
  logic lo_load, hi_load, commit_q;

  // 32-bit mode: either enable loads both halves
  assign lo_load = lo_en_i | (mode32_i & hi_en_i);
  assign hi_load = hi_en_i | (mode32_i & lo_en_i);
  assign hi_din  = mode32_i ? bus_i[WORD_W-1:HALF_W] : bus_i[HALF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      hi_q     <= '0;
      commit_q <= 1'b0;
    end else begin
      if (lo_load) lo_q <= bus_i[HALF_W-1:0];
      if (hi_load) hi_q <= hi_din;
      commit_q <= hi_load;
    end
  end

  assign word_o   = {hi_q, lo_q};
  assign commit_o = commit_q;

  assert_lo_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode32_i && lo_en_i && !hi_en_i) |=>
      (word_o[HALF_W-1:0] == $past(bus_i[HALF_W-1:0]) &&
       word_o[WORD_W-1:HALF_W] == $past(word_o[WORD_W-1:HALF_W])));
  assert_hi_half_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode32_i && hi_en_i) |=> word_o[WORD_W-1:HALF_W] == $past(bus_i[HALF_W-1:0]));
  assert_full_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode32_i && (lo_en_i || hi_en_i)) |=> word_o == $past(bus_i));
  assert_no_early_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode32_i && lo_en_i && !hi_en_i) |=> !commit_o);
  assert_commit_after_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_en_i |=> commit_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_en_i && !hi_en_i) |=> ($stable(word_o) && !commit_o));
endmodule

// File: rtl/wlc_read_capture.sv
module wlc_read_capture #(
  parameter int unsigned HALF_W = wlc_pkg::HALF_W,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode32_i,
  input  logic              cap_en_i,
  input  logic              hi_sel_i,
  input  wlc_pkg::rd_src_e  src_i,
  input  logic [WORD_W-1:0] reg_data_i,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] cap_q, cap_din;
  logic [HALF_W-1:0] half;

  assign cap_din = (src_i == wlc_pkg::SRC_MEM) ? mem_data_i : reg_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cap_q <= '0;
    else if (cap_en_i) cap_q <= cap_din;
  end

  assign half    = hi_sel_i ? cap_q[WORD_W-1:HALF_W] : cap_q[HALF_W-1:0];
  assign rdata_o = mode32_i ? cap_q : {{HALF_W{1'b0}}, half};

  assert_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_i |=> cap_q == $past(src_i == wlc_pkg::SRC_MEM ? mem_data_i : reg_data_i));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> $stable(cap_q));
  assert_upper_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode32_i |-> rdata_o[WORD_W-1:HALF_W] == '0);
endmodule

// File: rtl/wlc_bus_converter.sv
module wlc_bus_converter #(
  parameter int unsigned HALF_W = wlc_pkg::HALF_W,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode32_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  input  logic              wr_lo_en_i,
  input  logic              wr_hi_en_i,
  input  logic              rd_cap_en_i,
  input  logic              rd_hi_sel_i,
  input  logic              rd_src_mem_i,
  input  logic [WORD_W-1:0] reg_rdata_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] wdata_o,
  output logic              wr_commit_o,
  output logic [WORD_W-1:0] host_rdata_o
);
  wlc_pkg::rd_src_e rd_src;
  assign rd_src = wlc_pkg::rd_src_e'(rd_src_mem_i);

  wlc_write_capture #(.HALF_W(HALF_W)) u_wr (
    .clk_i, .rst_ni, .mode32_i,
    .bus_i   (host_wdata_i),
    .lo_en_i (wr_lo_en_i),
    .hi_en_i (wr_hi_en_i),
    .word_o  (wdata_o),
    .commit_o(wr_commit_o)
  );

  wlc_read_capture #(.HALF_W(HALF_W)) u_rd (
    .clk_i, .rst_ni, .mode32_i,
    .cap_en_i  (rd_cap_en_i),
    .hi_sel_i  (rd_hi_sel_i),
    .src_i     (rd_src),
    .reg_data_i(reg_rdata_i),
    .mem_data_i(mem_rdata_i),
    .rdata_o   (host_rdata_o)
  );

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (wdata_o == '0 && host_rdata_o == '0 && !wr_commit_o));
endmodule

// File: tb/wlc_bus_converter_bench.sv
module wlc_bus_converter_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode32 = 1'b0, lo_en = 1'b0, hi_en = 1'b0, cap_en = 1'b0, hi_sel = 1'b0, src_mem = 1'b0;
  logic [31:0] bus = '0, reg_d = '0, mem_d = '0;
  logic [31:0] wdata, rdata;
  logic commit;
  int errors = 0, checks = 0;

  // reference model state
  logic [15:0] m_lo = '0, m_hi = '0;
  logic [31:0] m_cap = '0;
  logic m_commit = 1'b0;
  string wtag = "R9", ctag = "R7";

  always #5 clk = ~clk;

  wlc_bus_converter u_wlc_bus_converter (
    .clk_i(clk), .rst_ni, .mode32_i(mode32), .host_wdata_i(bus),
    .wr_lo_en_i(lo_en), .wr_hi_en_i(hi_en), .rd_cap_en_i(cap_en),
    .rd_hi_sel_i(hi_sel), .rd_src_mem_i(src_mem),
    .reg_rdata_i(reg_d), .mem_rdata_i(mem_d),
    .wdata_o(wdata), .wr_commit_o(commit), .host_rdata_o(rdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    if (mode32) return m_cap;
    return {16'h0, hi_sel ? m_cap[31:16] : m_cap[15:0]};
  endfunction

  task automatic check_all();
    chk(wtag, wdata, {m_hi, m_lo});
    chk("R5", {31'b0, commit}, {31'b0, m_commit});
    chk(mode32 ? "R8" : "R7", rdata, exp_rd());
    if (ctag == "R6") chk("R6", rdata, exp_rd());
  endtask

  // one cycle: inputs already driven; model updates at the edge, check at negedge
  task automatic step();
    logic hl, ll;
    @(posedge clk);
    ll = lo_en | (mode32 & hi_en);
    hl = hi_en | (mode32 & lo_en);
    if (mode32 && (lo_en || hi_en)) wtag = "R4";
    else if (hi_en) wtag = "R3";
    else if (lo_en) wtag = "R2";
    else wtag = "R9";
    ctag = cap_en ? "R6" : "R7";
    if (ll) m_lo = bus[15:0];
    if (hl) m_hi = mode32 ? bus[31:16] : bus[15:0];
    m_commit = hl;
    if (cap_en) m_cap = src_mem ? mem_d : reg_d;
    @(negedge clk);
    check_all();
  endtask

  task automatic drive(logic m, logic l, logic h, logic c, logic s, logic src, logic [31:0] b);
    mode32 = m; lo_en = l; hi_en = h; cap_en = c; hi_sel = s; src_mem = src; bus = b;
    reg_d = $urandom; mem_d = $urandom;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bus = 32'hDEAD_BEEF; lo_en = 1'b1; hi_en = 1'b1; cap_en = 1'b1; mode32 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", wdata, 32'h0);
    chk("R1", rdata, 32'h0);
    chk("R1", {31'b0, commit}, 32'h0);
    drive(0, 0, 0, 0, 0, 0, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    // 16-bit write: low then high
    drive(0, 1, 0, 0, 0, 0, 32'hFFFF_1234); step();
    drive(0, 0, 1, 0, 0, 0, 32'hEEEE_5678); step();
    drive(0, 0, 0, 0, 0, 0, 32'h0);         step();
    // 32-bit write via one enable only
    drive(1, 1, 0, 0, 0, 0, 32'hA5A5_3C3C); step();
    drive(1, 0, 1, 0, 0, 0, 32'h0102_0304); step();
    // read from register space, then memory space, both halves
    drive(0, 0, 0, 1, 0, 0, 32'h0); step();
    drive(0, 0, 0, 0, 1, 0, 32'h0); step();
    drive(0, 0, 0, 1, 0, 1, 32'h0); step();
    drive(0, 0, 0, 0, 1, 1, 32'h0); step();
    // 32-bit read, select ignored
    drive(1, 0, 0, 0, 1, 0, 32'h0); step();
    drive(1, 0, 0, 0, 0, 0, 32'h0); step();
    // random traffic including mode switches mid-transfer
    for (int i = 0; i < 2000; i++) begin
      drive($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), $urandom);
      step();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule